// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block sits at the retire end of an in-order pipeline and decides, for each instruction that arrives there, whether it retires normally, traps to a handler, or retires and then takes a pending external interrupt. The earlier stages are outside the block. They hand over the instruction's PC and its predicted next PC, along with any exception recorded earlier. The memory stage may add a fault of its own. The external interrupt line is looked at only here, so every trap is taken in program order.

On a trap the unit writes the saved-PC register, the trap-code register and the privilege flag. It asserts a redirect with a fixed handler address and toggles a one-bit epoch. The epoch tag carried by younger instructions then no longer matches, so they are thrown away as they arrive. The unit also tells the scoreboard when to release an instruction's destination.

Top module: `trap_commit_unit`

## Requirements
- R1: After reset the saved PC, the trap code, the privilege flag and the epoch are all zero, and commit, scoreboard-release and redirect are low.
- R2: When an instruction carries an earlier-stage exception and also a memory-stage fault, the earlier-stage code is the one used. A memory-stage fault by itself counts as raised after register fetch.
- R3: A live instruction with an exception and no interrupt does not commit. In the cycle after, the saved PC equals its PC, the trap code equals its exception code and the privilege flag is 1.
- R4: A live instruction with an exception while the interrupt line is high does not commit. In the cycle after, the saved PC equals its PC, so it will be replayed, and the trap code equals IRQ_CODE (default 4'hF).
- R5: A live instruction without an exception while the interrupt line is high commits. In the cycle after, the saved PC equals its next PC, the trap code equals IRQ_CODE and the privilege flag is 1.
- R6: A live instruction without an exception and with the interrupt line low commits. It releases its scoreboard entry, does not redirect, and leaves the saved PC, the trap code and the epoch unchanged.
- R7: Scoreboard release is high for every commit. On a redirect it is high only if the exception was raised after register fetch, which is the late flag or a memory-stage fault.
- R8: Every redirect inverts the epoch in the following cycle. The epoch holds in every other cycle.
- R9: An instruction is live only when its valid bit is high and its epoch bit equals the current epoch. An instruction that is not live produces no strobe and changes no register, even with the interrupt line high.
- R10: While redirect is high the redirect target equals the HANDLER_PC parameter (default 32'h0000_0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An instruction is presented for retirement |
| in_epoch | input | 1 | Epoch tag of the presented instruction |
| in_pc | input | XLEN | PC of the instruction |
| in_npc | input | XLEN | Predicted next PC of the instruction |
| in_exc_valid | input | 1 | Exception recorded by an earlier stage |
| in_exc_code | input | 4 | Code of that exception |
| in_exc_late | input | 1 | That exception was raised after register fetch |
| mem_exc_valid | input | 1 | Fault detected by the memory stage |
| mem_exc_code | input | 4 | Code of the memory-stage fault |
| ext_irq | input | 1 | External interrupt request |
| commit_o | output | 1 | Instruction retires this cycle |
| sb_release_o | output | 1 | Release the instruction's scoreboard entry |
| redirect_o | output | 1 | Redirect fetch to the handler |
| redirect_pc_o | output | XLEN | Redirect target |
| epc_o | output | XLEN | Saved PC register |
| cause_o | output | 4 | Trap code register |
| priv_o | output | 1 | Privilege flag (1 = privileged) |
| epoch_o | output | 1 | Current epoch |

## Verification
The assertions check every cycle that each redirect inverts the epoch and that the epoch otherwise holds. They also check that a redirect leaves the unit privileged, that a commit always releases the scoreboard entry, that a dead instruction raises no strobe, and that the saved PC and the trap code move only after a redirect. The bench must show the rest: which PC is saved and which code is written in each combination of fault and interrupt, that the earlier-stage code wins over a memory fault, and when a redirect releases the scoreboard. It does this by sweeping every combination of valid, epoch match, both exception sources, the late flag and the interrupt, twice over, against a model of its own.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W = 4;

  typedef struct packed {
    logic               vld;
    logic               late;
    logic [CAUSE_W-1:0] code;
  } exc_t;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_RETIRE,
    ACT_TRAP,
    ACT_REPLAY_IRQ,
    ACT_RETIRE_IRQ
  } act_e;
endpackage

// File: rtl/exc_merge.sv
module exc_merge
  import trap_pkg::*;
(
  input  logic               early_vld,
  input  logic [CAUSE_W-1:0] early_code,
  input  logic               early_late,
  input  logic               mem_vld,
  input  logic [CAUSE_W-1:0] mem_code,
  output exc_t               merged
);
  always_comb begin
    merged = '0;
    if (early_vld) begin
      merged.vld  = 1'b1;
      merged.late = early_late;
      merged.code = early_code;
    end else if (mem_vld) begin
      merged.vld  = 1'b1;
      merged.late = 1'b1;
      merged.code = mem_code;
    end
  end
endmodule

// File: rtl/commit_decide.sv
module commit_decide
  import trap_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] IRQ_CODE = 4'hF
) (
  input  logic               live,
  input  exc_t               exc,
  input  logic               irq,
  output act_e               act,
  output logic               commit,
  output logic               sb_release,
  output logic               redirect,
  output logic               save_npc,
  output logic [CAUSE_W-1:0] new_code
);
  always_comb begin
    if (!live)                act = ACT_IDLE;
    else if (exc.vld && irq)  act = ACT_REPLAY_IRQ;
    else if (exc.vld)         act = ACT_TRAP;
    else if (irq)             act = ACT_RETIRE_IRQ;
    else                      act = ACT_RETIRE;
  end

  always_comb begin
    commit     = 1'b0;
    sb_release = 1'b0;
    redirect   = 1'b0;
    save_npc   = 1'b0;
    new_code   = exc.code;
    unique case (act)
      ACT_RETIRE: begin
        commit     = 1'b1;
        sb_release = 1'b1;
      end
      ACT_TRAP: begin
        redirect   = 1'b1;
        sb_release = exc.late;
      end
      ACT_REPLAY_IRQ: begin
        redirect   = 1'b1;
        sb_release = exc.late;
        new_code   = IRQ_CODE;
      end
      ACT_RETIRE_IRQ: begin
        commit     = 1'b1;
        sb_release = 1'b1;
        redirect   = 1'b1;
        save_npc   = 1'b1;
        new_code   = IRQ_CODE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [XLEN-1:0]    epc_d,
  input  logic [CAUSE_W-1:0] code_d,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] code_q,
  output logic               priv_q,
  output logic               epoch_q
);
  logic [XLEN-1:0]    epc_n;
  logic [CAUSE_W-1:0] code_n;
  logic               priv_n;
  logic               epoch_n;

  always_comb begin
    epc_n   = epc_q;
    code_n  = code_q;
    priv_n  = priv_q;
    epoch_n = epoch_q;
    if (wr_en) begin
      epc_n   = epc_d;
      code_n  = code_d;
      priv_n  = 1'b1;
      epoch_n = ~epoch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      code_q  <= '0;
      priv_q  <= 1'b0;
      epoch_q <= 1'b0;
    end else begin
      epc_q   <= epc_n;
      code_q  <= code_n;
      priv_q  <= priv_n;
      epoch_q <= epoch_n;
    end
  end
endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
  import trap_pkg::*;
#(
  parameter int                 XLEN       = 32,
  parameter logic [XLEN-1:0]    HANDLER_PC = 32'h0000_0100,
  parameter logic [CAUSE_W-1:0] IRQ_CODE   = 4'hF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_epoch,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [XLEN-1:0]    in_npc,
  input  logic               in_exc_valid,
  input  logic [CAUSE_W-1:0] in_exc_code,
  input  logic               in_exc_late,
  input  logic               mem_exc_valid,
  input  logic [CAUSE_W-1:0] mem_exc_code,
  input  logic               ext_irq,
  output logic               commit_o,
  output logic               sb_release_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               priv_o,
  output logic               epoch_o
);
  logic [1:0]         rst_pipe;
  logic               rst_s_n;
  exc_t               exc;
  act_e               act;
  logic               live;
  logic               save_npc;
  logic [CAUSE_W-1:0] new_code;
  logic [XLEN-1:0]    epc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign live = rst_s_n && in_valid && (in_epoch == epoch_o);

  exc_merge u_merge (
    .early_vld (in_exc_valid),
    .early_code(in_exc_code),
    .early_late(in_exc_late),
    .mem_vld   (mem_exc_valid),
    .mem_code  (mem_exc_code),
    .merged    (exc)
  );

  commit_decide #(.IRQ_CODE(IRQ_CODE)) u_decide (
    .live      (live),
    .exc       (exc),
    .irq       (ext_irq),
    .act       (act),
    .commit    (commit_o),
    .sb_release(sb_release_o),
    .redirect  (redirect_o),
    .save_npc  (save_npc),
    .new_code  (new_code)
  );

  assign epc_d         = save_npc ? in_npc : in_pc;
  assign redirect_pc_o = HANDLER_PC;

  trap_state_regs #(.XLEN(XLEN)) u_state (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (redirect_o),
    .epc_d  (epc_d),
    .code_d (new_code),
    .epc_q  (epc_o),
    .code_q (cause_o),
    .priv_q (priv_o),
    .epoch_q(epoch_o)
  );

  assert_epoch_flip_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    redirect_o |=> (epoch_o != $past(epoch_o)));
  assert_epoch_hold_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !redirect_o |=> $stable(epoch_o));
  assert_priv_after_trap_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    redirect_o |=> priv_o);
  assert_commit_releases_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit_o |-> sb_release_o);
  assert_dead_quiet_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!in_valid || in_epoch != epoch_o) |-> !(commit_o || sb_release_o || redirect_o));
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !redirect_o |=> ($stable(epc_o) && $stable(cause_o) && $stable(priv_o)));
  assert_act_known_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (act == ACT_IDLE) |-> !redirect_o);
endmodule

// File: tb/trap_commit_unit_tb.sv
`timescale 1ns/1ps
module trap_commit_unit_tb;
  localparam int          XLEN = 32;
  localparam logic [31:0] HPC  = 32'h0000_0100;
  localparam logic [3:0]  IRQC = 4'hF;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_epoch, in_exc_valid, in_exc_late, mem_exc_valid, ext_irq;
  logic [XLEN-1:0] in_pc, in_npc;
  logic [3:0] in_exc_code, mem_exc_code;
  logic commit_o, sb_release_o, redirect_o, priv_o, epoch_o;
  logic [XLEN-1:0] redirect_pc_o, epc_o;
  logic [3:0] cause_o;

  int checks = 0;
  int bad = 0;
  logic m_epoch, m_priv;
  logic [XLEN-1:0] m_epc;
  logic [3:0] m_cause;

  always #10 clk = ~clk;

  trap_commit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_epoch(in_epoch),
    .in_pc(in_pc), .in_npc(in_npc), .in_exc_valid(in_exc_valid),
    .in_exc_code(in_exc_code), .in_exc_late(in_exc_late),
    .mem_exc_valid(mem_exc_valid), .mem_exc_code(mem_exc_code),
    .ext_irq(ext_irq), .commit_o(commit_o), .sb_release_o(sb_release_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .epc_o(epc_o),
    .cause_o(cause_o), .priv_o(priv_o), .epoch_o(epoch_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {in_valid, in_epoch, in_exc_valid, in_exc_late, mem_exc_valid, ext_irq} = '0;
    in_pc = '0; in_npc = '0; in_exc_code = '0; mem_exc_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "epc", epc_o, 0);
    check("R1", "cause", {28'd0, cause_o}, 0);
    check("R1", "priv", {31'd0, priv_o}, 0);
    check("R1", "epoch", {31'd0, epoch_o}, 0);
    check("R1", "strobes", {29'd0, commit_o, sb_release_o, redirect_o}, 0);
    m_epoch = 1'b0; m_priv = 1'b0; m_epc = '0; m_cause = '0;

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 64; i++) begin
        logic v, mt, hc, cl, mf, irq, eff, late, live, red;
        logic [3:0] code;
        string tag;
        v = i[0]; mt = i[1]; hc = i[2]; cl = i[3]; mf = i[4]; irq = i[5];
        @(negedge clk);
        in_valid = v; in_epoch = mt ? m_epoch : ~m_epoch;
        in_exc_valid = hc; in_exc_late = cl; mem_exc_valid = mf; ext_irq = irq;
        in_exc_code = 4'(i % 7 + 1);
        mem_exc_code = 4'(i % 5 + 9);
        in_pc = 32'h1000 + 32'(pass * 512 + i * 4);
        in_npc = in_pc + 32'h40;
        eff = hc | mf;
        code = hc ? in_exc_code : mem_exc_code;
        late = hc ? cl : 1'b1;
        live = v & mt;
        red = live & (eff | irq);
        if (!live) tag = "R9";
        else if (eff && !irq) tag = (hc && mf) ? "R2" : "R3";
        else if (eff) tag = "R4";
        else if (irq) tag = "R5";
        else tag = "R6";
        #2;
        check(tag, "commit", {31'd0, commit_o}, {31'd0, live & ~eff});
        check(tag, "redirect", {31'd0, redirect_o}, {31'd0, red});
        check("R7", "sb_release", {31'd0, sb_release_o}, {31'd0, live & (~eff | late)});
        if (red) check("R10", "redirect_pc", redirect_pc_o, HPC);
        if (red) begin
          m_epc = eff ? in_pc : in_npc;
          m_cause = irq ? IRQC : code;
          m_priv = 1'b1;
          m_epoch = ~m_epoch;
        end
        @(posedge clk);
        #2;
        check(tag, "epc", epc_o, m_epc);
        check(tag, "cause", {28'd0, cause_o}, {28'd0, m_cause});
        check(tag, "priv", {31'd0, priv_o}, {31'd0, m_priv});
        check("R8", "epoch", {31'd0, epoch_o}, {31'd0, m_epoch});
      end
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule